// File: doc/BRIEF.md
# Burst-capable link frame transmitter

This block is the sending end of a point-to-point packet link. Packets arrive from the core clock domain through a valid/ready handshake. Each carries an address, a data word, a write flag and a stream flag. They leave as a byte stream with a frame line, driven from a fast clock that runs at exactly four times the core rate. The core domain makes every decision: framing, burst detection, header formation and wait handling. Each core cycle it produces one four-byte beat. The fast domain only shifts that beat out, one byte per fast cycle.

A frame opens with one header beat, then an address beat and a data beat. Consecutive write packets can share the frame. In normal mode each next address must be 4 higher than the last. In stream mode the address must stay the same. Such a packet adds only its data beat, and the frame line stays high. The header bit and the unbroken frame both tell the receiver about a burst. The receiver can push back with an asynchronous wait line. This line is synchronized once, in the fast domain. While it is high, the block accepts no new packet, so an open burst closes after the packet already in flight. Once wait is released, traffic starts again with a fresh header.

Top module: `link_burst_tx`

## Requirements
- R1: While `rst` is high, `in_ready`, `tx_frame` and `tx_active` are low. `tx_active` goes high at the first core edge with `rst` low.
- R2: Each core-cycle beat leaves on four consecutive fast cycles, most significant byte first. `tx_frame` and `tx_burst` hold their value for all four bytes.
- R3: A frame opens with a header byte, then three zero bytes, then the four address bytes (most significant first), then the four data bytes (most significant first). Header bit 0 is the write flag. Header bit 1 is set for writes and means a burst may follow. Header bit 2 is the stream flag. Header bits 7:3 are zero.
- R4: A packet continues the frame only if all of these hold: it is accepted during the data beat of the previous packet, both packets are writes, and their stream flags match. In addition, its address must equal the previous address plus 4 when the stream flag is clear, or equal the previous address when it is set. Such a packet sends only its four data bytes, and `tx_frame` stays high.
- R5: A packet accepted during a data beat that fails R4 lowers `tx_frame` for one beat and then opens a new frame. If no packet is accepted in a data beat, the frame closes.
- R6: `tx_burst` is high on exactly the data bytes of continuation packets.
- R7: `in_ready` is low in the two core cycles after an accept from idle. It is high in the data beat and while idle. The opening packet's data beat is the third core cycle after an accept from idle, and the fourth after an accept that forced a frame break.
- R8: Once `link_wait` is held high, `in_ready` is low from the second core cycle onward. The open frame closes after the packet in flight. Every accepted packet appears in the stream exactly once.
- R9: After `link_wait` is released, the next packet opens a new frame with a header.
- R10: `tx_done` is low in the core cycle after any accept, including a continuation. It goes high once a frame closes with no new accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| clk4 | input | 1 | Serial clock, four times the core clock, edge aligned |
| rst | input | 1 | Synchronous active-high reset |
| link_wait | input | 1 | Asynchronous pushback from the receiver |
| in_valid | input | 1 | Packet offered |
| in_ready | output | 1 | Packet taken when both are high |
| in_write | input | 1 | Packet is a write |
| in_stream | input | 1 | Fixed-address stream mode |
| in_addr | input | AW | Packet address |
| in_data | input | DW | Packet data word |
| tx_byte | output | BW | Serial byte lane |
| tx_frame | output | 1 | Frame line |
| tx_burst | output | 1 | Marks continuation data bytes |
| tx_done | output | 1 | Link has closed its last frame |
| tx_active | output | 1 | Transmitter is out of reset and ready |

## Verification
A burst-continuation decision and a wait arrival can fall in the same data beat. The wait synchronizer then closes the frame at the very core edge where an eligible next packet would otherwise have extended it. The bench provokes this by holding a long contiguous burst and raising `link_wait` at four different sub-cycle offsets of the fast clock. Each offset lands the synchronized wait on a different beat of the packet pipeline. The bench builds the expected stream from the handshakes it actually observes, using the cycle rules of R4, R5 and R7. It then compares the stream byte by byte: every accepted packet must appear once, in a frame that was either closed or continued exactly as those rules predict, and the first frame after the release must start with a header.

// File: rtl/lbt_pkg.sv
package lbt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_ADDR,
    ST_DATA,
    ST_GAP
  } lbt_state_t;

  localparam int HB_WRITE  = 0;
  localparam int HB_OPEN   = 1;
  localparam int HB_STREAM = 2;
endpackage

// File: rtl/lbt_wait_sync.sv
module lbt_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk4,
  input  logic rst,
  input  logic wait_async,
  output logic wait_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk4) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], wait_async};
  end

  assign wait_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lbt_frame_ctrl.sv
module lbt_frame_ctrl
  import lbt_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wait_f,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_write,
  input  logic          in_stream,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic [DW-1:0] beat_word,
  output logic          beat_frame,
  output logic          beat_burst,
  output logic          beat_tog,
  output logic          done,
  output logic          active
);
  localparam int ADDR_STEP = DW / 8;

  lbt_state_t    st_q, st_d;
  logic          wait_c;
  logic          active_q;
  logic          tog_q;
  logic          done_q;
  logic          burst_q;
  logic          cur_write, cur_stream;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_data;
  logic          acc, cont, addr_ok;
  logic [BW-1:0] hdr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_c   <= 1'b0;
      active_q <= 1'b0;
      tog_q    <= 1'b0;
    end else begin
      wait_c   <= wait_f;
      active_q <= 1'b1;
      tog_q    <= ~tog_q;
    end
  end

  assign in_ready = active_q && !wait_c && (st_q == ST_IDLE || st_q == ST_DATA);
  assign acc      = in_valid && in_ready;
  assign addr_ok  = cur_stream ? (in_addr == cur_addr)
                               : (in_addr == cur_addr + AW'(ADDR_STEP));
  assign cont     = (st_q == ST_DATA) && in_write && cur_write &&
                    (in_stream == cur_stream) && addr_ok;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (acc) st_d = ST_HDR;
      ST_HDR:  st_d = ST_ADDR;
      ST_ADDR: st_d = ST_DATA;
      ST_DATA: begin
        if (!acc)     st_d = ST_IDLE;
        else if (cont) st_d = ST_DATA;
        else          st_d = ST_GAP;
      end
      ST_GAP:  st_d = ST_HDR;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      done_q  <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      burst_q <= acc && cont;
      if (acc)                  done_q <= 1'b0;
      else if (st_q == ST_DATA) done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      cur_write  <= in_write;
      cur_stream <= in_stream;
      cur_addr   <= in_addr;
      cur_data   <= in_data;
    end
  end

  always_comb begin
    hdr             = '0;
    hdr[HB_WRITE]   = cur_write;
    hdr[HB_OPEN]    = cur_write;
    hdr[HB_STREAM]  = cur_stream;
  end

  always_comb begin
    case (st_q)
      ST_HDR:  beat_word = {hdr, {(DW-BW){1'b0}}};
      ST_ADDR: beat_word = DW'(cur_addr);
      ST_DATA: beat_word = cur_data;
      default: beat_word = '0;
    endcase
  end

  assign beat_frame = (st_q == ST_HDR) || (st_q == ST_ADDR) || (st_q == ST_DATA);
  assign beat_burst = burst_q;
  assign beat_tog   = tog_q;
  assign done       = done_q;
  assign active     = active_q;

  // R7: an accept from idle leads to the header beat with input closed
  a_r7_idle_to_header: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && acc) |=> (st_q == ST_HDR && !in_ready));

  // R4: a continuation keeps the frame high and marks the beat as burst
  a_r4_continue_beat: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DATA && acc && cont) |=> (beat_frame && beat_burst && st_q == ST_DATA));

  // R5: a non-continuing packet in the data beat forces a low-frame beat
  a_r5_break_gap: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DATA && acc && !cont) |=> (!beat_frame && !in_ready));

  // R5: no accept in the data beat closes the frame
  a_r5_close_idle: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DATA && !acc) |=> (st_q == ST_IDLE && !beat_frame));

  // R10: any accept clears the done flag
  a_r10_done_clear: assert property (@(posedge clk) disable iff (rst)
    acc |=> !done_q);
endmodule

// File: rtl/lbt_serializer.sv
module lbt_serializer #(
  parameter int BW    = 8,
  parameter int LANES = 4
) (
  input  logic                clk4,
  input  logic                rst,
  input  logic [BW*LANES-1:0] beat_word,
  input  logic                beat_frame,
  input  logic                beat_burst,
  input  logic                beat_tog,
  output logic [BW-1:0]       tx_byte,
  output logic                tx_frame,
  output logic                tx_burst
);
  localparam int WW = BW * LANES;
  localparam int RW = WW - BW;
  localparam int CW = $clog2(LANES + 1);

  logic          tog_q;
  logic          load;
  logic [RW-1:0] rest_q;
  logic [BW-1:0] byte_q;
  logic          frame_q, burst_q;

  always_ff @(posedge clk4) begin
    if (rst) tog_q <= 1'b0;
    else     tog_q <= beat_tog;
  end

  assign load = beat_tog ^ tog_q;

  always_ff @(posedge clk4) begin
    if (load) begin
      byte_q <= beat_word[WW-1 -: BW];
      rest_q <= beat_word[RW-1:0];
    end else begin
      byte_q <= rest_q[RW-1 -: BW];
      rest_q <= rest_q << BW;
    end
  end

  always_ff @(posedge clk4) begin
    if (rst) begin
      frame_q <= 1'b0;
      burst_q <= 1'b0;
    end else if (load) begin
      frame_q <= beat_frame;
      burst_q <= beat_burst;
    end
  end

  assign tx_byte  = byte_q;
  assign tx_frame = frame_q;
  assign tx_burst = burst_q;

  logic [CW-1:0] since_q;
  logic          seen_q;
  always_ff @(posedge clk4) begin
    if (rst) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (load) begin
      since_q <= '0;
      seen_q  <= 1'b1;
    end else if (since_q != CW'(LANES)) begin
      since_q <= since_q + 1'b1;
    end
  end

  // R2: beats are loaded exactly once every LANES fast cycles
  a_r2_beat_period: assert property (@(posedge clk4) disable iff (rst)
    (load && seen_q) |-> (since_q == CW'(LANES - 1)));

  // R2: frame and burst lines hold between loads
  a_r2_lines_held: assert property (@(posedge clk4) disable iff (rst)
    !$past(load) |-> ($stable(frame_q) && $stable(burst_q)));
endmodule

// File: rtl/link_burst_tx.sv
module link_burst_tx #(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int BW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          clk4,
  input  logic          rst,
  input  logic          link_wait,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_write,
  input  logic          in_stream,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic [BW-1:0] tx_byte,
  output logic          tx_frame,
  output logic          tx_burst,
  output logic          tx_done,
  output logic          tx_active
);
  localparam int LANES = DW / BW;

  logic          wait_f;
  logic [DW-1:0] beat_word;
  logic          beat_frame, beat_burst, beat_tog;

  lbt_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk4       (clk4),
    .rst        (rst),
    .wait_async (link_wait),
    .wait_sync  (wait_f)
  );

  lbt_frame_ctrl #(.AW(AW), .DW(DW), .BW(BW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wait_f     (wait_f),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_write   (in_write),
    .in_stream  (in_stream),
    .in_addr    (in_addr),
    .in_data    (in_data),
    .beat_word  (beat_word),
    .beat_frame (beat_frame),
    .beat_burst (beat_burst),
    .beat_tog   (beat_tog),
    .done       (tx_done),
    .active     (tx_active)
  );

  lbt_serializer #(.BW(BW), .LANES(LANES)) u_ser (
    .clk4       (clk4),
    .rst        (rst),
    .beat_word  (beat_word),
    .beat_frame (beat_frame),
    .beat_burst (beat_burst),
    .beat_tog   (beat_tog),
    .tx_byte    (tx_byte),
    .tx_frame   (tx_frame),
    .tx_burst   (tx_burst)
  );
endmodule

// File: tb/link_burst_tx_test.sv
`timescale 1ns/1ps
module link_burst_tx_test;
  logic        clk = 0, clk4 = 0, rst = 1, link_wait = 0;
  logic        in_valid = 0, in_write = 0, in_stream = 0;
  logic [31:0] in_addr = 0, in_data = 0;
  logic        in_ready, tx_frame, tx_burst, tx_done, tx_active;
  logic [7:0]  tx_byte;

  link_burst_tx uut (
    .clk(clk), .clk4(clk4), .rst(rst), .link_wait(link_wait),
    .in_valid(in_valid), .in_ready(in_ready), .in_write(in_write),
    .in_stream(in_stream), .in_addr(in_addr), .in_data(in_data),
    .tx_byte(tx_byte), .tx_frame(tx_frame), .tx_burst(tx_burst),
    .tx_done(tx_done), .tx_active(tx_active)
  );

  int n_checks = 0, n_fails = 0;
  int ph = 0, cyc = 0;

  initial begin
    forever begin
      #1.25 clk4 = 1;
      if (ph == 0) clk = 1;
      else if (ph == 2) clk = 0;
      ph = (ph + 1) % 4;
      #1.25 clk4 = 0;
    end
  end
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // observed stream, sampled away from the fast edge
  byte unsigned ob[$]; bit ou[$]; int of[$];
  int ofid = 0; bit prev_fr = 0; bit frame_now = 0;
  always @(negedge clk4) begin
    frame_now = tx_frame;
    if (!rst && tx_frame) begin
      if (!prev_fr) ofid++;
      ob.push_back(tx_byte); ou.push_back(tx_burst); of.push_back(ofid);
    end
    prev_fr = tx_frame;
  end

  // expected stream
  byte unsigned eb[$]; bit eu[$]; int ef[$]; string et[$];
  int efid = 0;
  bit have_prev = 0, after_wait = 0;
  int ncE = 0, last_acc = -100;
  bit pw_w, pw_s; logic [31:0] pw_a;

  task automatic push_word(input logic [31:0] w, input bit u, input string tag);
    for (int i = 3; i >= 0; i--) begin
      eb.push_back(w[i*8 +: 8]); eu.push_back(u); ef.push_back(efid); et.push_back(tag);
    end
  endtask

  function automatic bit elig(input bit w1, input bit s1, input logic [31:0] a1,
                              input bit w2, input bit s2, input logic [31:0] a2);
    return w1 && w2 && (s1 == s2) && (s1 ? (a2 == a1) : (a2 == a1 + 32'd4));
  endfunction

  // packet list
  logic [31:0] pa[$], pd[$]; bit pwq[$], psq[$]; int pg[$];
  task automatic add_pkt(input bit w, input bit s, input logic [31:0] a,
                         input logic [31:0] d, input int gap);
    pwq.push_back(w); psq.push_back(s); pa.push_back(a); pd.push_back(d); pg.push_back(gap);
  endtask

  task automatic model_accept(input int a, input int idx);
    bit w = pwq[idx], s = psq[idx];
    logic [31:0] ad = pa[idx], da = pd[idx];
    bit newf;
    newf = 1;
    if (have_prev && a < ncE) begin
      check(0, "R7", "accept before data beat (edge)", a, ncE);
      ncE = a + 3;
    end else if (!have_prev || a > ncE) begin
      ncE = a + 3;
    end else if (elig(pw_w, pw_s, pw_a, w, s, ad)) begin
      newf = 0; ncE = a + 1;
    end else begin
      ncE = a + 4;
    end
    check(tx_done == 0, "R10", "done after accept", tx_done, 0);
    if (newf) begin
      efid++;
      push_word({5'b0, s, w, w, 24'h0}, 0, after_wait ? "R9" : "R3");
      after_wait = 0;
      push_word(ad, 0, "R2");
      push_word(da, 0, "R3");
    end else begin
      push_word(da, 1, "R4");
    end
    have_prev = 1; pw_w = w; pw_s = s; pw_a = ad; last_acc = a;
  endtask

  task automatic run(input int wait_at, input real woff, input int wait_len);
    int k = 0, idx = 0, gap, n, pend_edge = 0, c;
    bit pend = 0, quiet;
    n = pa.size();
    gap = (n > 0) ? pg[0] : 0;
    while (idx < n || pend || (wait_at >= 0 && k <= wait_at + wait_len + 4)) begin
      @(negedge clk); k++; c = cyc;
      if (pend) begin
        model_accept(pend_edge, idx);
        idx++; pend = 0;
        gap = (idx < n) ? pg[idx] : 0;
      end
      if (k == wait_at) fork begin automatic real d = woff; #(d) link_wait = 1; end join_none
      if (k == wait_at + wait_len) fork begin automatic real d = woff; #(d) link_wait = 0; after_wait = 1; end join_none
      quiet = (wait_at < 0) || (k < wait_at) || (k > wait_at + wait_len + 3);
      if (wait_at >= 0 && k >= wait_at + 2 && k < wait_at + wait_len)
        check(in_ready == 0, "R8", "ready under wait", in_ready, 0);
      if (wait_at >= 0 && k == wait_at + wait_len - 1)
        check(frame_now == 0, "R8", "frame closed under wait", frame_now, 0);
      if (have_prev && c >= last_acc && c <= ncE - 2)
        check(in_ready == 0, "R7", "ready during header/address", in_ready, 0);
      else if (have_prev && quiet)
        check(in_ready == 1, "R7", "ready in data beat or idle", in_ready, 1);
      if (have_prev && last_acc < ncE && c >= ncE)
        check(tx_done == 1, "R10", "done after close", tx_done, 1);
      if (idx < n && gap == 0) begin
        in_valid = 1; in_write = pwq[idx]; in_stream = psq[idx];
        in_addr = pa[idx]; in_data = pd[idx];
      end else begin
        in_valid = 0;
        if (gap > 0) gap--;
      end
      if (in_valid && in_ready) begin pend = 1; pend_edge = cyc + 1; end
    end
    in_valid = 0;
    repeat (6) @(negedge clk);
    pa.delete(); pd.delete(); pwq.delete(); psq.delete(); pg.delete();
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #500000;
    check(0, "R8", "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    int pid = 0;
    // R1: reset state
    repeat (4) @(negedge clk);
    check(in_ready == 0, "R1", "ready in reset", in_ready, 0);
    check(tx_active == 0, "R1", "active in reset", tx_active, 0);
    check(frame_now == 0, "R1", "frame in reset", frame_now, 0);
    rst = 0;
    @(negedge clk);
    check(tx_active == 1, "R1", "active after reset", tx_active, 1);
    check(in_ready == 1, "R1", "ready after reset", in_ready, 1);

    // pair sweep: every kind of second packet against every first
    for (int w1 = 0; w1 < 2; w1++)
      for (int s1 = 0; s1 < 2; s1++)
        for (int w2 = 0; w2 < 2; w2++)
          for (int s2 = 0; s2 < 2; s2++)
            for (int dsel = 0; dsel < 3; dsel++) begin
              logic [31:0] base = 32'h1000_0000 + 32'(pid) * 64;
              logic [31:0] a2 = base + ((dsel == 0) ? 32'd4 : (dsel == 1) ? 32'd0 : 32'd8);
              add_pkt(w1[0], s1[0], base, 32'hA500_0000 + 32'(pid), 3);
              add_pkt(w2[0], s2[0], a2,   32'h5A00_0000 + 32'(pid), 0);
              pid++;
            end
    run(-1, 0.0, 0);

    // bursts of several lengths in both address modes
    for (int s = 0; s < 2; s++)
      for (int len = 1; len <= 5; len++)
        for (int i = 0; i < len; i++)
          add_pkt(1, s[0], 32'h2000_0000 + 32'(len) * 256 + (s ? 32'd0 : 32'(i) * 4),
                  32'hC000_0000 + 32'(s * 64 + len * 8 + i), (i == 0) ? 3 : 0);
    // a valid hole inside a burst closes the frame
    add_pkt(1, 0, 32'h3000_0000, 32'h11, 3);
    add_pkt(1, 0, 32'h3000_0004, 32'h22, 0);
    add_pkt(1, 0, 32'h3000_0008, 32'h33, 1);
    run(-1, 0.0, 0);

    // wait during a long burst at four fast-clock offsets
    for (int o = 0; o < 4; o++) begin
      for (int i = 0; i < 14; i++)
        add_pkt(1, 0, 32'h4000_0000 + 32'(o) * 4096 + 32'(i) * 4,
                32'hD000_0000 + 32'(o * 32 + i), (i == 0) ? 3 : 0);
      run(7 + o, 0.3 + 1.3 * o, 9);
    end

    repeat (20) @(negedge clk);
    check(tx_done == 1, "R10", "done when link idle", tx_done, 1);
    check(ob.size() == eb.size(), "R8", "stream byte count", ob.size(), eb.size());
    for (int i = 0; i < eb.size() && i < ob.size(); i++) begin
      check(ob[i] == eb[i], et[i], $sformatf("byte %0d", i), ob[i], eb[i]);
      check(ou[i] == eu[i], "R6", $sformatf("burst flag %0d", i), ou[i], eu[i]);
      check(of[i] == ef[i], "R5", $sformatf("frame id %0d", i), of[i], ef[i]);
    end
    finish_run();
  end
endmodule